// File: doc/BRIEF.md
# Memory Device Test Access Port

This block is the serial test port of a memory device. A test controller steps it through the standard sixteen-state test state machine with TMS on each rising TCK edge and moves data in on TDI and out on TDO. A three-bit instruction chooses which scan register sits between TDI and TDO. The choices are a one-bit bypass stage, a 32-bit identification register loaded from a parameter, or a 107-cell boundary chain. The boundary chain has a capture/shift stage and a separate update stage.

The boundary update stage feeds the pads, which sit outside this block. One update cell, position 47, is the enable of the functional data bus while the external-test instruction is current. A separate instruction parks the data bus in high-Z. The port does not interact with normal memory traffic. Its only effect on the memory's pins is through the bus override outputs.

Top module: `mem_test_port`

## Requirements
- R1: The state machine advances on each rising TCK edge according to TMS. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state.
- R2: `tdo` and `tdo_en` change only on falling TCK edges. `tdo_en` is high exactly while the state is Shift-IR or Shift-DR. `tdo` is 0 whenever `tdo_en` is low.
- R3: The instruction register is 3 bits wide. In Capture-IR it loads 3'b001, so the first two bits shifted out are 1 then 0, and the third bit is 0.
- R4: The IDCODE instruction (3'b001) is current after power-on reset and after every pass through Test-Logic-Reset.
- R5: A shifted instruction becomes current only in Update-IR. The current instruction holds through Capture-IR, Shift-IR and Exit1-IR.
- R6: Under IDCODE, the DR path is the 32-bit ID register. It loads `ID_CODE` in Capture-DR and shifts it out bit 0 first, followed by the TDI bits.
- R7: BYPASS (3'b111) and the three reserved codes (3'b011, 3'b101, 3'b110) select a one-bit register. That register captures 0, so the TDI stream comes out one cycle late.
- R8: EXTEST (3'b000), SAMPLE Z (3'b010) and SAMPLE/PRELOAD (3'b100) select the 107-cell boundary chain. In Capture-DR it loads `pin_sample`. TDI enters cell 106 and cell 0 drives TDO. New preload data shifts in while the snapshot shifts out.
- R9: In Update-DR, `bsr_drive` takes the chain contents when a boundary instruction is current. Under any other instruction a DR scan leaves `bsr_drive` unchanged.
- R10: While EXTEST is current, `ext_mode` and `bus_ovr` are high and `bus_oe` equals `bsr_drive[47]`.
- R11: While SAMPLE Z is current, `bus_ovr` is high, `bus_oe` is low and `ext_mode` is low.
- R12: Update cell 47 is 1 after power-on reset and after Test-Logic-Reset. All other update cells are 0 after power-on.
- R13: Under IDCODE, BYPASS, SAMPLE/PRELOAD and reserved codes, `ext_mode` and `bus_ovr` are low and `bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| pin_sample | input | 107 | Parallel snapshot of the device pins |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | TDO drive enable, high in the shift states |
| bsr_drive | output | 107 | Boundary update stage, values for the pads |
| ext_mode | output | 1 | External-test instruction is current; pads use `bsr_drive` |
| bus_ovr | output | 1 | Data-bus enable is overridden by the test port |
| bus_oe | output | 1 | Overriding data-bus enable (1 drives, 0 high-Z) |

## Verification
The preset of update cell 47 is the hardest behaviour to reach from the ports. It is visible only as `bus_oe` under EXTEST. It must be shown to return to 1 after Test-Logic-Reset even when a preload had cleared it.

The stimulus first preloads a 0 into cell 47 through SAMPLE/PRELOAD and confirms the bus goes high-Z under EXTEST. It then drives five TMS-high cycles and loads EXTEST again with no DR scan in between. The bench also forces a reset from inside the IR path, while a non-default instruction is current. It then reads the ID register back to prove IDCODE was restored.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {DP_BYP, DP_ID, DP_BSR} dr_path_t;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_PRELOAD = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;

  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    case (s)
      TS_RESET:  return m ? TS_RESET  : TS_IDLE;
      TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return m ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  return m ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: return m ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: return m ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  return m ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: return m ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: return m ? TS_SEL_DR : TS_IDLE;
      default:   return TS_RESET;
    endcase
  endfunction

  function automatic dr_path_t dr_path(input logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:                        return DP_ID;
      OP_EXTEST, OP_SAMPLEZ, OP_PRELOAD: return DP_BSR;
      default:                          return DP_BYP;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_t st
);
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) st <= TS_RESET;
    else        st <= tap_next(st, tms);
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  logic            do_cap,
  input  logic            do_shift,
  input  logic            do_upd,
  input  logic            in_reset,
  output logic [IR_W-1:0] ir_cur,
  output logic [IR_W-1:0] ir_shift
);
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_shift <= IR_CAPTURE;
      ir_cur   <= OP_IDCODE;
    end else begin
      if (do_cap)        ir_shift <= IR_CAPTURE;
      else if (do_shift) ir_shift <= {tdi, ir_shift[IR_W-1:1]};
      if (in_reset)      ir_cur <= OP_IDCODE;
      else if (do_upd)   ir_cur <= ir_shift;
    end
  end
endmodule

// File: rtl/tap_bsr.sv
module tap_bsr #(
  parameter int LEN     = 107,
  parameter int OE_CELL = 47
) (
  input  logic           tck,
  input  logic           por_n,
  input  logic           tdi,
  input  logic           sel,
  input  logic           do_cap,
  input  logic           do_shift,
  input  logic           do_upd,
  input  logic           in_reset,
  input  logic [LEN-1:0] pins,
  output logic           ser_out,
  output logic [LEN-1:0] upd_q
);
  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] ser_in;

  assign ser_in  = {tdi, sh_q[LEN-1:1]};
  assign ser_out = sh_q[0];

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    localparam logic PRESET = (i == OE_CELL);

    always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                sh_q[i] <= 1'b0;
      else if (sel && do_cap)    sh_q[i] <= pins[i];
      else if (sel && do_shift)  sh_q[i] <= ser_in[i];
    end

    always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                upd_q[i] <= PRESET;
      else if (PRESET && in_reset) upd_q[i] <= 1'b1;
      else if (sel && do_upd)    upd_q[i] <= sh_q[i];
    end
  end
endmodule

// File: rtl/mem_test_port.sv
module mem_test_port
  import tap_pkg::*;
#(
  parameter int              ID_W    = 32,
  parameter logic [ID_W-1:0] ID_CODE = 32'h1A2B_C0DF,
  parameter int              BSR_LEN = 107,
  parameter int              OE_CELL = 47
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_sample,
  output logic               tdo,
  output logic               tdo_en,
  output logic [BSR_LEN-1:0] bsr_drive,
  output logic               ext_mode,
  output logic               bus_ovr,
  output logic               bus_oe
);
  tap_state_t      st;
  logic [IR_W-1:0] ir_cur;
  logic [IR_W-1:0] ir_shift;
  logic [ID_W-1:0] id_q;
  logic            byp_q;
  logic            bsr_lsb;
  dr_path_t        path;

  // decoded events, named for the checker
  logic st_rst, st_cap_dr, st_sh_dr, st_upd_dr, st_cap_ir, st_sh_ir, st_upd_ir;
  logic sel_bsr, sel_id, sel_byp, upd47, dr_lsb;

  assign st_rst    = (st == TS_RESET);
  assign st_cap_dr = (st == TS_CAP_DR);
  assign st_sh_dr  = (st == TS_SH_DR);
  assign st_upd_dr = (st == TS_UPD_DR);
  assign st_cap_ir = (st == TS_CAP_IR);
  assign st_sh_ir  = (st == TS_SH_IR);
  assign st_upd_ir = (st == TS_UPD_IR);

  assign path    = dr_path(ir_cur);
  assign sel_bsr = (path == DP_BSR);
  assign sel_id  = (path == DP_ID);
  assign sel_byp = (path == DP_BYP);

  tap_fsm u_fsm (.tck(tck), .por_n(por_n), .tms(tms), .st(st));

  tap_ir u_ir (
    .tck(tck), .por_n(por_n), .tdi(tdi),
    .do_cap(st_cap_ir), .do_shift(st_sh_ir), .do_upd(st_upd_ir), .in_reset(st_rst),
    .ir_cur(ir_cur), .ir_shift(ir_shift)
  );

  tap_bsr #(.LEN(BSR_LEN), .OE_CELL(OE_CELL)) u_bsr (
    .tck(tck), .por_n(por_n), .tdi(tdi), .sel(sel_bsr),
    .do_cap(st_cap_dr), .do_shift(st_sh_dr), .do_upd(st_upd_dr), .in_reset(st_rst),
    .pins(pin_sample), .ser_out(bsr_lsb), .upd_q(bsr_drive)
  );

  // identification and bypass stages
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      id_q  <= '0;
      byp_q <= 1'b0;
    end else begin
      if (sel_id && st_cap_dr)      id_q <= ID_CODE;
      else if (sel_id && st_sh_dr)  id_q <= {tdi, id_q[ID_W-1:1]};
      if (sel_byp && st_cap_dr)     byp_q <= 1'b0;
      else if (sel_byp && st_sh_dr) byp_q <= tdi;
    end
  end

  assign dr_lsb = sel_bsr ? bsr_lsb : (sel_id ? id_q[0] : byp_q);

  // serial output launched on the falling edge
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= st_sh_ir | st_sh_dr;
      tdo    <= st_sh_ir ? ir_shift[0] : (st_sh_dr ? dr_lsb : 1'b0);
    end
  end

  assign upd47    = bsr_drive[OE_CELL];
  assign ext_mode = (ir_cur == OP_EXTEST);
  assign bus_ovr  = ext_mode | (ir_cur == OP_SAMPLEZ);
  assign bus_oe   = ext_mode & upd47;

endmodule

// File: rtl/tap_chk.sv
module tap_chk
  import tap_pkg::*;
(
  input logic            tck,
  input logic            por_n,
  input logic            tms,
  input tap_state_t      st,
  input logic [IR_W-1:0] ir_cur,
  input logic [IR_W-1:0] ir_shift,
  input logic            byp_q,
  input logic            sel_byp,
  input logic            tdo,
  input logic            tdo_en,
  input logic            bus_ovr,
  input logic            bus_oe,
  input logic            upd47
);
  logic [2:0] ones_run;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)              ones_run <= 3'd0;
    else if (!tms)           ones_run <= 3'd0;
    else if (ones_run != 3'd7) ones_run <= ones_run + 3'd1;
  end

  a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!por_n)
    (ones_run >= 3'd5) |-> (st == TS_RESET));

  a_r2_tdo_en_in_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en |-> (st == TS_SH_DR || st == TS_SH_IR));

  a_r2_tdo_quiet: assert property (@(posedge tck) disable iff (!por_n)
    !tdo_en |-> !tdo);

  a_r3_capture_ir: assert property (@(posedge tck) disable iff (!por_n)
    (st == TS_CAP_IR) |=> (ir_shift[1:0] == 2'b01));

  a_r4_reset_idcode: assert property (@(posedge tck) disable iff (!por_n)
    (st == TS_RESET) |=> (ir_cur == OP_IDCODE));

  a_r5_ir_hold: assert property (@(posedge tck) disable iff (!por_n)
    (st != TS_UPD_IR && st != TS_RESET) |=> $stable(ir_cur));

  a_r7_bypass_capture: assert property (@(posedge tck) disable iff (!por_n)
    (st == TS_CAP_DR && sel_byp) |=> !byp_q);

  a_r11_samplez_hiz: assert property (@(posedge tck) disable iff (!por_n)
    (ir_cur == OP_SAMPLEZ) |-> (bus_ovr && !bus_oe));

  a_r12_oe_preset: assert property (@(posedge tck) disable iff (!por_n)
    (st == TS_RESET) |=> upd47);
endmodule

bind mem_test_port tap_chk u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .st(st), .ir_cur(ir_cur),
  .ir_shift(ir_shift), .byp_q(byp_q), .sel_byp(sel_byp), .tdo(tdo),
  .tdo_en(tdo_en), .bus_ovr(bus_ovr), .bus_oe(bus_oe), .upd47(upd47)
);

// File: tb/mem_test_port_test.sv
module mem_test_port_test;
  localparam logic [31:0] IDV = 32'h5C3A_9E17;
  localparam int LEN = 107;
  localparam int N   = 120;

  // {opcode, path: 0 bypass, 1 id, 2 boundary}
  localparam logic [4:0] VEC [8] = '{
    {3'b001, 2'd1}, {3'b111, 2'd0}, {3'b100, 2'd2}, {3'b000, 2'd2},
    {3'b010, 2'd2}, {3'b011, 2'd0}, {3'b101, 2'd0}, {3'b110, 2'd0}
  };

  logic tck = 1'b0;
  logic por_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [LEN-1:0] pin_sample = '0;
  logic tdo, tdo_en, ext_mode, bus_ovr, bus_oe;
  logic [LEN-1:0] bsr_drive;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;
  logic [LEN-1:0] exp_upd;

  always #2 tck = ~tck;

  mem_test_port #(.ID_CODE(IDV)) uut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_sample(pin_sample),
    .tdo(tdo), .tdo_en(tdo_en), .bsr_drive(bsr_drive), .ext_mode(ext_mode),
    .bus_ovr(bus_ovr), .bus_oe(bus_oe)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic scan_dr(input logic [127:0] din, output logic [127:0] dout, output logic en_ok);
    dout = '0;
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    dout[0] = tdo;
    en_ok = tdo_en;
    for (int i = 0; i < N; i++) begin
      tick(i == N - 1, din[i]);
      if (i < N - 1) begin
        dout[i+1] = tdo;
        en_ok = en_ok & tdo_en;
      end
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic scan_ir(input logic [2:0] op, output logic [2:0] dout, output logic held);
    logic pre;
    pre = ext_mode;
    held = 1'b1;
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    dout[0] = tdo;
    held = held & (ext_mode == pre);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, op[i]);
      if (i < 2) dout[i+1] = tdo;
      held = held & (ext_mode == pre);
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic tlr_to_idle();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  function automatic logic [127:0] pat(input int k);
    logic [31:0] w;
    w = 32'h9E37_79B9 ^ (32'(k) * 32'h0101_0133);
    return {w, ~w, {w[15:0], w[31:16]}, w ^ 32'h3C3C_A5A5};
  endfunction

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] dout, din, expv;
    logic [2:0] irout;
    logic en_ok, held;
    logic [2:0] op;
    logic [1:0] pth;

    exp_upd = '0;
    exp_upd[47] = 1'b1;
    repeat (3) @(negedge tck);
    #1;
    check("R2 reset tdo_en/tdo", {126'd0, tdo_en, tdo}, 128'd0);
    check("R12 reset update stage", 128'(bsr_drive), 128'(exp_upd));
    check("R13 reset bus outputs", {125'd0, ext_mode, bus_ovr, bus_oe}, 128'd0);
    por_n = 1'b1;
    tick(1'b0, 1'b0);

    // R4/R6: IDCODE current straight after power-on
    din = pat(99);
    scan_dr(din, dout, en_ok);
    check("R4 R6 id after power-on", dout, 128'({din[N-33:0], IDV}));
    check("R2 tdo_en idle", {126'd0, tdo_en, tdo}, 128'd0);

    // table walk
    for (int k = 0; k < 8; k++) begin
      op  = VEC[k][4:2];
      pth = VEC[k][1:0];
      scan_ir(op, irout, held);
      check("R3 ir capture 001", 128'(irout), 128'(3'b001));
      check("R5 instruction held until update", 128'(held), 128'd1);
      expv = '0;
      expv[2] = (op == 3'b000);
      expv[1] = (op == 3'b000) || (op == 3'b010);
      expv[0] = (op == 3'b000) && exp_upd[47];
      check((op == 3'b000) ? "R10 extest bus" : (op == 3'b010) ? "R11 samplez bus" : "R13 bus idle",
            {125'd0, ext_mode, bus_ovr, bus_oe}, expv);
      pin_sample = pat(k + 20)[LEN-1:0];
      din = pat(k);
      scan_dr(din, dout, en_ok);
      check("R2 tdo_en during shift", 128'(en_ok), 128'd1);
      if (pth == 2'd1)
        check("R6 id path", dout, 128'({din[N-33:0], IDV}));
      else if (pth == 2'd0)
        check("R7 bypass path", dout, 128'({din[N-2:0], 1'b0}));
      else begin
        check("R8 boundary path", dout, 128'({din[N-LEN-1:0], pin_sample}));
        exp_upd = din[N-1:N-LEN];
      end
      check("R9 update stage", 128'(bsr_drive), 128'(exp_upd));
    end

    // R1/R4: reset forced from inside the IR path with BYPASS current
    scan_ir(3'b111, irout, held);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    tlr_to_idle();
    din = pat(55);
    scan_dr(din, dout, en_ok);
    check("R1 R4 five ones restore idcode", dout, 128'({din[N-33:0], IDV}));

    // R12: cell 47 cleared by preload, then preset by Test-Logic-Reset
    scan_ir(3'b100, irout, held);
    din = '0;
    scan_dr(din, dout, en_ok);
    exp_upd = '0;
    check("R9 preload zeros", 128'(bsr_drive), 128'd0);
    scan_ir(3'b000, irout, held);
    check("R10 extest bus high-z", {125'd0, ext_mode, bus_ovr, bus_oe}, 128'(3'b110));
    tlr_to_idle();
    exp_upd[47] = 1'b1;
    check("R12 preset after reset", 128'(bsr_drive), 128'(exp_upd));
    scan_ir(3'b000, irout, held);
    check("R12 R10 extest bus drives", {125'd0, ext_mode, bus_ovr, bus_oe}, 128'(3'b111));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule